// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block is a register-mapped timer with four independent down-counters and one shared interrupt set. Each channel has four word registers: a load value, a read-only current count, a control word and a background reload value. The control word turns the channel on, chooses between wrap to all-ones and reload on zero, sets a prescale of 1, 16 or 256, picks 16- or 32-bit counting, and can make the channel stop at zero. Software can turn the falling count into a rising one by negating it.

A load write does not take effect at once. It is taken in on the channel's next prescaled tick while the channel is enabled, so software that needs to know when it has landed polls the count for any change. A background reload write never touches the running count. It only changes the value that a periodic channel reloads when it next passes through zero. Each channel raises its raw interrupt bit when a decrement brings it to zero. A shared mask gates these bits onto a single interrupt line, and writing ones to a clear register drops them.

The register port is a plain synchronous write strobe with a combinational read path on byte addresses. Only word-aligned addresses decode. Shared registers take block 0 of 16 bytes, and channel n takes block n+1.

Top module: `quad_dtimer`

## Requirements
- R1: After reset every register reads zero, every channel is disabled and in 16-bit mode, and `irq_o` is low.
- R2: A write to a channel's load register (offset 0x0 in its block) sets a pending flag and does not change the count read at offset 0x4. The value is copied into the count on the next prescaled tick while the channel is enabled, and a disabled channel keeps the flag until it is enabled.
- R3: An enabled channel decrements by one per prescaled tick. Control bits 3:2 = 00 gives a tick every clock, 01 every 16 clocks and 10 or 11 every 256 clocks. A load write restarts the prescale phase, so the loaded value appears exactly N clocks after the write edge and each later decrement follows N clocks apart.
- R4: Raw interrupt bit n (shared offset 0x04) sets on the tick where channel n decrements from one to zero. It does not set at any other count.
- R5: Shared offset 0x00 holds a read/write interrupt mask. Offset 0x08 reads raw AND mask, and `irq_o` is high exactly when that AND is nonzero.
- R6: Writing a 1 to bit n of shared offset 0x0C clears raw bit n. Zero bits leave the other raw bits unchanged, and a new zero event in the same cycle wins over the clear.
- R7: With control bit 0 (one-shot) set, a channel that reaches zero stays at zero until a new load write restarts it.
- R8: With bits 0 and 6 clear (free-running), a channel at zero wraps on its next tick to the all-ones value of its width: 0xFFFFFFFF in 32-bit mode, 0xFFFF in 16-bit mode.
- R9: With bit 6 set and bit 0 clear (periodic), a channel at zero reloads on its next tick from the last value written to either the load or the background register. A write to the background register (offset 0xC) never changes the current count by itself.
- R10: With control bit 1 clear the channel counts in 16 bits. Loaded values are truncated to their low 16 bits, and the count reads with bits 31:16 zero.
- R11: With control bit 7 clear the count holds its value.
- R12: Control reads back only bits 7, 6, 3, 2, 1, 0. Misaligned addresses and blocks past the last channel read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | OR of the masked raw interrupt bits |

## Verification
The bench uses the default parameters: four channels, 32-bit words, a 16-bit narrow mode and prescale shifts of 4 and 8. With these values the 16-bit wrap to 0xFFFF and both prescale dividers can be reached within a few hundred clocks, so the exact tick latency after a load write can be measured at every divider. The 32-bit wrap is reached from zero, and the pending-load behaviour is checked on a channel that is disabled and then re-enabled.

// File: rtl/qdt_pkg.sv
package qdt_pkg;

   localparam int CTL_W      = 8;
   localparam int CTL_EN     = 7;
   localparam int CTL_PER    = 6;
   localparam int CTL_PRE_HI = 3;
   localparam int CTL_PRE_LO = 2;
   localparam int CTL_W32    = 1;
   localparam int CTL_ONE    = 0;

   localparam logic [CTL_W-1:0] CTL_KEEP = 8'hCF;

   localparam logic [1:0] SUB_LOAD = 2'd0;
   localparam logic [1:0] SUB_VAL  = 2'd1;
   localparam logic [1:0] SUB_CTL  = 2'd2;
   localparam logic [1:0] SUB_BG   = 2'd3;

   localparam logic [1:0] SUB_MASK = 2'd0;
   localparam logic [1:0] SUB_RAW  = 2'd1;
   localparam logic [1:0] SUB_MIS  = 2'd2;
   localparam logic [1:0] SUB_CLR  = 2'd3;

   typedef enum logic [1:0] {
      PRE_DIV1   = 2'b00,
      PRE_DIV_A  = 2'b01,
      PRE_DIV_B  = 2'b10,
      PRE_DIV_B2 = 2'b11
   } pre_sel_e;

endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler #(
   parameter int SHIFT_A = 4,
   parameter int SHIFT_B = 8
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       restart_i,
   input  logic       run_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);
   import qdt_pkg::*;

   localparam logic [SHIFT_B-1:0] MASK_A = {{(SHIFT_B-SHIFT_A){1'b0}}, {SHIFT_A{1'b1}}};
   localparam logic [SHIFT_B-1:0] MASK_B = '1;

   logic [SHIFT_B-1:0] phase_q;
   logic [SHIFT_B-1:0] sel_mask;

   always_comb begin
      unique case (pre_sel_e'(sel_i))
         PRE_DIV1:  sel_mask = '0;
         PRE_DIV_A: sel_mask = MASK_A;
         default:   sel_mask = MASK_B;
      endcase
   end

   assign tick_o = run_i && ((phase_q & sel_mask) == sel_mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        phase_q <= '0;
      else if (restart_i) phase_q <= '0;
      else if (run_i)     phase_q <= phase_q + 1'b1;
   end

endmodule

// File: rtl/qdt_channel.sv
module qdt_channel #(
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int SHIFT_A  = 4,
   parameter int SHIFT_B  = 8
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     ld_we_i,
   input  logic                     bg_we_i,
   input  logic                     ctl_we_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic [DATA_W-1:0]        val_o,
   output logic [DATA_W-1:0]        ld_o,
   output logic [DATA_W-1:0]        bg_o,
   output logic [qdt_pkg::CTL_W-1:0] ctl_o,
   output logic                     hit_o,
   output logic [DATA_W-1:0]        cnt_o,
   output logic                     pend_o,
   output logic                     en_o,
   output logic                     w32_o,
   output logic                     os_o
);
   import qdt_pkg::*;

   localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [CTL_W-1:0]  ctl_q;
   logic [DATA_W-1:0] ld_q, rl_q, cnt_q, cnt_d, cur, wmask;
   logic              pend_q, pend_d, tick, hit;
   logic              en, per, w32, one;

   assign en  = ctl_q[CTL_EN];
   assign per = ctl_q[CTL_PER];
   assign w32 = ctl_q[CTL_W32];
   assign one = ctl_q[CTL_ONE];

   qdt_prescaler #(.SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (ld_we_i),
      .run_i     (en),
      .sel_i     (ctl_q[CTL_PRE_HI:CTL_PRE_LO]),
      .tick_o    (tick)
   );

   assign wmask = w32 ? '1 : NARROW_MASK;
   assign cur   = cnt_q & wmask;

   always_comb begin
      cnt_d = cnt_q;
      hit   = 1'b0;
      if (tick) begin
         if (pend_q) begin
            cnt_d = ld_q & wmask;
         end else if (cur == '0) begin
            if (one)      cnt_d = '0;
            else if (per) cnt_d = rl_q & wmask;
            else          cnt_d = wmask;
         end else begin
            cnt_d = cur - 1'b1;
            hit   = (cur == {{(DATA_W-1){1'b0}}, 1'b1});
         end
      end
   end

   always_comb begin
      pend_d = pend_q;
      if (tick)    pend_d = 1'b0;
      if (ld_we_i) pend_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q  <= '0;
         ld_q   <= '0;
         rl_q   <= '0;
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         pend_q <= pend_d;
         if (ctl_we_i) ctl_q <= wdata_i[CTL_W-1:0] & CTL_KEEP;
         if (ld_we_i) begin
            ld_q <= wdata_i;
            rl_q <= wdata_i;
         end else if (bg_we_i) begin
            rl_q <= wdata_i;
         end
      end
   end

   assign val_o  = cur;
   assign ld_o   = ld_q;
   assign bg_o   = rl_q;
   assign ctl_o  = ctl_q;
   assign hit_o  = hit;
   assign cnt_o  = cnt_q;
   assign pend_o = pend_q;
   assign en_o   = en;
   assign w32_o  = w32;
   assign os_o   = one;

endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
   parameter int NUM_CH = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_CH-1:0] hit_i,
   input  logic              mask_we_i,
   input  logic [NUM_CH-1:0] mask_wdata_i,
   input  logic [NUM_CH-1:0] clr_i,
   output logic [NUM_CH-1:0] raw_o,
   output logic [NUM_CH-1:0] mask_o,
   output logic              irq_o
);
   logic [NUM_CH-1:0] raw_q, mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_i) | hit_i;
         if (mask_we_i) mask_q <= mask_wdata_i;
      end
   end

   assign raw_o  = raw_q;
   assign mask_o = mask_q;
   assign irq_o  = |(raw_q & mask_q);

endmodule

// File: rtl/quad_dtimer.sv
module quad_dtimer #(
   parameter int NUM_CH   = 4,
   parameter int DATA_W   = 32,
   parameter int NARROW_W = 16,
   parameter int ADDR_W   = 8,
   parameter int SHIFT_A  = 4,
   parameter int SHIFT_B  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   import qdt_pkg::*;

   localparam int BLK_W = ADDR_W - 4;

   if (NUM_CH < 1 || NUM_CH + 1 > (1 << BLK_W)) begin : g_bad_ch
      $error("quad_dtimer: NUM_CH does not fit the address space");
   end
   if (DATA_W < CTL_W || NARROW_W < 1 || NARROW_W >= DATA_W) begin : g_bad_w
      $error("quad_dtimer: width parameters out of range");
   end
   if (SHIFT_A < 1 || SHIFT_B <= SHIFT_A) begin : g_bad_pre
      $error("quad_dtimer: prescale shifts must satisfy 1 <= SHIFT_A < SHIFT_B");
   end
   if (NUM_CH > DATA_W) begin : g_bad_irq
      $error("quad_dtimer: interrupt bits exceed the word width");
   end

   logic [BLK_W-1:0] blk;
   logic [1:0]       sub;
   logic             aligned;

   assign blk     = reg_addr_i[ADDR_W-1:4];
   assign sub     = reg_addr_i[3:2];
   assign aligned = (reg_addr_i[1:0] == 2'b00);

   logic [NUM_CH-1:0] ch_en, ch_w32, ch_os, ch_pend, ch_ldwe, ch_hit, clr_req, raw, msk;
   logic [NUM_CH-1:0][DATA_W-1:0] ch_cnt, ch_val, ch_ld, ch_bg;
   logic [NUM_CH-1:0][CTL_W-1:0]  ch_ctl;
   logic shared_we;

   assign shared_we = reg_we_i && aligned && (blk == '0);
   assign clr_req   = (shared_we && sub == SUB_CLR) ? reg_wdata_i[NUM_CH-1:0] : '0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel        = reg_we_i && aligned && (blk == BLK_W'(i + 1));
      assign ch_ldwe[i] = sel && (sub == SUB_LOAD);

      qdt_channel #(
         .DATA_W   (DATA_W),
         .NARROW_W (NARROW_W),
         .SHIFT_A  (SHIFT_A),
         .SHIFT_B  (SHIFT_B)
      ) u_ch (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .ld_we_i  (ch_ldwe[i]),
         .bg_we_i  (sel && (sub == SUB_BG)),
         .ctl_we_i (sel && (sub == SUB_CTL)),
         .wdata_i  (reg_wdata_i),
         .val_o    (ch_val[i]),
         .ld_o     (ch_ld[i]),
         .bg_o     (ch_bg[i]),
         .ctl_o    (ch_ctl[i]),
         .hit_o    (ch_hit[i]),
         .cnt_o    (ch_cnt[i]),
         .pend_o   (ch_pend[i]),
         .en_o     (ch_en[i]),
         .w32_o    (ch_w32[i]),
         .os_o     (ch_os[i])
      );
   end

   qdt_irq #(.NUM_CH(NUM_CH)) u_irq (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .hit_i        (ch_hit),
      .mask_we_i    (shared_we && sub == SUB_MASK),
      .mask_wdata_i (reg_wdata_i[NUM_CH-1:0]),
      .clr_i        (clr_req),
      .raw_o        (raw),
      .mask_o       (msk),
      .irq_o        (irq_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (aligned) begin
         if (blk == '0) begin
            unique case (sub)
               SUB_MASK: reg_rdata_o = DATA_W'(msk);
               SUB_RAW:  reg_rdata_o = DATA_W'(raw);
               SUB_MIS:  reg_rdata_o = DATA_W'(raw & msk);
               default:  reg_rdata_o = '0;
            endcase
         end
         for (int i = 0; i < NUM_CH; i++) begin
            if (blk == BLK_W'(i + 1)) begin
               unique case (sub)
                  SUB_LOAD: reg_rdata_o = ch_ld[i];
                  SUB_VAL:  reg_rdata_o = ch_val[i];
                  SUB_CTL:  reg_rdata_o = DATA_W'(ch_ctl[i]);
                  default:  reg_rdata_o = ch_bg[i];
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 32
) (
   input logic                          clk_i,
   input logic                          rst_ni,
   input logic [NUM_CH-1:0]             en_i,
   input logic [NUM_CH-1:0]             w32_i,
   input logic [NUM_CH-1:0]             os_i,
   input logic [NUM_CH-1:0]             pend_i,
   input logic [NUM_CH-1:0]             ldwe_i,
   input logic [NUM_CH-1:0]             hit_i,
   input logic [NUM_CH-1:0]             clr_i,
   input logic [NUM_CH-1:0]             raw_i,
   input logic [NUM_CH-1:0]             mask_i,
   input logic                          irq_i,
   input logic [NUM_CH-1:0][DATA_W-1:0] cnt_i,
   input logic [NUM_CH-1:0][DATA_W-1:0] val_i
);
   // R5: the interrupt line follows the masked raw bits
   p_irq_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i == (|(raw_i & mask_i)));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R11
      p_hold_disabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !en_i[i] |=> $stable(cnt_i[i]));
      // R3
      p_step_by_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (en_i[i] && w32_i[i] && !pend_i[i] && cnt_i[i] > 1)
         |=> (cnt_i[i] == $past(cnt_i[i]) || cnt_i[i] == $past(cnt_i[i]) - 1));
      // R4
      p_raw_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(raw_i[i]) |-> (val_i[i] == '0));
      // R7
      p_oneshot_stays_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (en_i[i] && os_i[i] && w32_i[i] && val_i[i] == '0 && !pend_i[i] && !ldwe_i[i])
         |=> (val_i[i] == '0));
      // R6
      p_clear_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[i] && !hit_i[i]) |=> !raw_i[i]);
   end
endmodule

bind quad_dtimer qdt_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_qdt_checker (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .en_i   (ch_en),
   .w32_i  (ch_w32),
   .os_i   (ch_os),
   .pend_i (ch_pend),
   .ldwe_i (ch_ldwe),
   .hit_i  (ch_hit),
   .clr_i  (clr_req),
   .raw_i  (raw),
   .mask_i (msk),
   .irq_i  (irq_o),
   .cnt_i  (ch_cnt),
   .val_i  (ch_val)
);

// File: tb/test_quad_dtimer.sv
module test_quad_dtimer;
   localparam int  AW = 8;
   localparam int  DW = 32;
   localparam time CLK_P = 20ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   quad_dtimer i_quad_dtimer (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_we_i    (we),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   localparam logic [AW-1:0] A_MASK = 8'h00, A_RAW = 8'h04, A_MIS = 8'h08, A_CLR = 8'h0C;

   function automatic logic [AW-1:0] ch_addr(int ch, int sub);
      return AW'(16 * (ch + 1) + 4 * sub);
   endfunction

   task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      rd(A_MASK, v);           check("R1 mask", v, 0);
      rd(A_RAW, v);            check("R1 raw", v, 0);
      rd(ch_addr(0, 1), v);    check("R1 count", v, 0);
      rd(ch_addr(3, 2), v);    check("R1 control", v, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic t_load_latency;
      logic [DW-1:0] v;
      wr(ch_addr(0, 0), 100);
      wr(ch_addr(0, 2), 32'h82);
      rd(ch_addr(0, 1), v);    check("R2 not yet visible", v, 0);
      idle(1);
      rd(ch_addr(0, 1), v);    check("R2 load taken", v, 100);
      idle(5);
      rd(ch_addr(0, 1), v);    check("R3 div1 decrement", v, 95);
   endtask

   task automatic t_zero_irq;
      logic [DW-1:0] v;
      wr(ch_addr(0, 0), 10);
      idle(10);
      rd(ch_addr(0, 1), v);    check("R3 count one", v, 1);
      rd(A_RAW, v);            check("R4 no raw before zero", v, 0);
      idle(1);
      rd(ch_addr(0, 1), v);    check("R4 count zero", v, 0);
      rd(A_RAW, v);            check("R4 raw set", v, 1);
      check("R5 irq masked off", irq, 0);
      idle(1);
      rd(ch_addr(0, 1), v);    check("R8 32-bit wrap", v, 32'hFFFF_FFFF);
      wr(A_MASK, 1);
      rd(A_MASK, v);           check("R5 mask readback", v, 1);
      rd(A_MIS, v);            check("R5 masked status", v, 1);
      check("R5 irq high", irq, 1);
      wr(A_CLR, 1);
      rd(A_RAW, v);            check("R6 raw cleared", v, 0);
      check("R6 irq low", irq, 0);
   endtask

   task automatic t_narrow;
      logic [DW-1:0] v;
      wr(ch_addr(1, 0), 32'h0001_2345);
      wr(ch_addr(1, 2), 32'h80);
      idle(1);
      rd(ch_addr(1, 1), v);    check("R10 truncated load", v, 32'h2345);
      wr(ch_addr(1, 0), 3);
      idle(4);
      rd(ch_addr(1, 1), v);    check("R10 at zero", v, 0);
      idle(1);
      rd(ch_addr(1, 1), v);    check("R8 16-bit wrap", v, 32'h0000_FFFF);
      rd(A_RAW, v);            check("R4 raw bit of channel 1", v, 2);
      wr(A_CLR, 1);
      rd(A_RAW, v);            check("R6 other bit untouched", v, 2);
      wr(A_CLR, 2);
      rd(A_RAW, v);            check("R6 bit1 cleared", v, 0);
   endtask

   task automatic t_oneshot_and_hold;
      logic [DW-1:0] v;
      wr(ch_addr(2, 0), 4);
      wr(ch_addr(2, 2), 32'h83);
      idle(5);
      rd(ch_addr(2, 1), v);    check("R7 reached zero", v, 0);
      idle(10);
      rd(ch_addr(2, 1), v);    check("R7 stays at zero", v, 0);
      wr(ch_addr(2, 0), 2);
      idle(1);
      rd(ch_addr(2, 1), v);    check("R7 reload restarts", v, 2);
      wr(ch_addr(2, 2), 32'h03);
      rd(ch_addr(2, 1), v);    check("R11 last tick before disable", v, 1);
      wr(ch_addr(2, 0), 9);
      idle(5);
      rd(ch_addr(2, 1), v);    check("R11 disabled holds", v, 1);
      wr(ch_addr(2, 2), 32'h83);
      idle(1);
      rd(ch_addr(2, 1), v);    check("R2 pending load on enable", v, 9);
   endtask

   task automatic t_periodic;
      logic [DW-1:0] v;
      wr(ch_addr(3, 0), 5);
      wr(ch_addr(3, 2), 32'hC2);
      idle(2);
      rd(ch_addr(3, 1), v);    check("R9 counting", v, 4);
      wr(ch_addr(3, 3), 8);
      rd(ch_addr(3, 1), v);    check("R9 background no immediate effect", v, 3);
      rd(ch_addr(3, 3), v);    check("R9 background readback", v, 8);
      rd(ch_addr(3, 0), v);    check("R9 load readback", v, 5);
      idle(3);
      rd(ch_addr(3, 1), v);    check("R9 at zero", v, 0);
      idle(1);
      rd(ch_addr(3, 1), v);    check("R9 reload from background", v, 8);
   endtask

   task automatic t_prescale;
      logic [DW-1:0] v;
      wr(ch_addr(0, 2), 32'h86);
      wr(ch_addr(0, 0), 50);
      idle(16);
      rd(ch_addr(0, 1), v);    check("R3 div16 load after 16", v, 50);
      idle(15);
      rd(ch_addr(0, 1), v);    check("R3 div16 hold", v, 50);
      idle(1);
      rd(ch_addr(0, 1), v);    check("R3 div16 step", v, 49);
      wr(ch_addr(1, 2), 32'h88);
      wr(ch_addr(1, 0), 7);
      idle(256);
      rd(ch_addr(1, 1), v);    check("R3 div256 load after 256", v, 7);
      idle(255);
      rd(ch_addr(1, 1), v);    check("R3 div256 hold", v, 7);
      idle(1);
      rd(ch_addr(1, 1), v);    check("R3 div256 step", v, 6);
   endtask

   task automatic t_decode;
      logic [DW-1:0] v;
      wr(ch_addr(3, 2), 32'hB2);
      rd(ch_addr(3, 2), v);    check("R12 control unused bits", v, 32'h82);
      wr(8'h51, 32'hFF);
      rd(8'h50, v);            check("R12 past last channel", v, 0);
      rd(8'h41, v);            check("R12 misaligned", v, 0);
      rd(A_MASK, v);           check("R12 misaligned write ignored", v, 1);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_load_latency();
      t_zero_irq();
      t_narrow();
      t_oneshot_and_hold();
      t_periodic();
      t_prescale();
      t_decode();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule